// File: doc/BRIEF.md
# Oldest Redirect Selection Arbiter

This block decides which control-flow redirect leaves the core back-end in a given cycle. It collects redirect requests from a parameterized number of branch and jump write-back ports and from a parameterized number of load-violation ports. Each request carries a reorder-buffer position, given as a circular index value plus a wrap flag. It also carries a flag that says whether the redirecting instruction must itself be re-executed, a fetch-queue pointer with an instruction offset, and a carried target. A commit-time pipeline flush enters through a separate port and always takes priority over the execution-side requests.

Execution-side requests are registered once. Any request that is not older than the redirect issued in the current cycle is discarded at every stage. The arbiter finds the oldest survivor among the branch ports, then the oldest among the load ports, and then picks the older of those two. After one more cycle the winner is combined with a base PC read from the fetch-address memory. That memory lies outside the block: the block drives the read pointer and takes the read data back on an input. The output is a redirect record, a three-slot one-hot source select, and a look-ahead copy of each candidate's queue pointer that is valid one cycle before the record.

Top module: `redirect_arbiter`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_sel_oh` is all zeros.
- R2: An execution-side request held for one cycle appears on the output 3 clock edges after it was sampled, counting the sampling edge. A commit flush appears 2 edges after its sampling edge.
- R3: Among valid branch-port requests, the oldest by reorder-buffer age wins. On equal age, the lowest port number wins. The winner's index, wrap flag, flush-self flag and queue pointer appear unchanged on the output.
- R4: The branch winner and the load winner are compared. The load winner is chosen only if it is strictly older. On equal age the branch winner is chosen.
- R5: Index A is older than index B when the two wrap flags are equal and A's value is smaller, or when the two wrap flags differ and A's value is larger.
- R6: While a redirect is on the output, every execution-side request at the input, in the first register stage or in the second stage is dropped if it is younger than that redirect. A request of equal age is also dropped, but only if the redirect on the output has its flush-self flag set.
- R7: A commit flush in its delay stage always produces the output record. An execution-side candidate that is in the second stage in the same cycle is discarded.
- R8: `out_sel_oh` is 3'b001 for a branch-port redirect, 3'b010 for a load-port redirect and 3'b100 for a commit flush. It is zero when `out_valid` is 0.
- R9: `ahead_ftq[0]` and `ahead_ftq[1]` carry the queue pointers of the branch winner and the load winner held in the second stage. `ahead_ftq[2]` carries the queue pointer of the delayed flush. Each is valid one cycle before the output record.
- R10: `out_pc` equals `base_pc` plus the offset times 4. `out_target` equals `out_pc` when the flush-self flag is set. Otherwise it equals `out_pc + 4` for a commit flush and the carried target for a branch or load redirect.
- R11: `pc_rd_ftq` is the queue pointer of the delayed flush when one is present, and otherwise the pointer of the second-stage candidate. The next output record carries that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exu_valid | input | NUM_EXU | Branch/jump request valid per port |
| exu_rob | input | NUM_EXU x ROB_W | Reorder-buffer index value per port |
| exu_wrap | input | NUM_EXU | Reorder-buffer wrap flag per port |
| exu_self | input | NUM_EXU | Flush-self flag per port |
| exu_ftq | input | NUM_EXU x FTQ_W | Fetch-queue pointer per port |
| exu_off | input | NUM_EXU x OFF_W | Instruction offset within the fetch block |
| exu_target | input | NUM_EXU x PC_W | Carried redirect target |
| ld_valid | input | NUM_LD | Load-violation request valid per port |
| ld_rob | input | NUM_LD x ROB_W | Reorder-buffer index value per port |
| ld_wrap | input | NUM_LD | Reorder-buffer wrap flag per port |
| ld_self | input | NUM_LD | Flush-self flag per port |
| ld_ftq | input | NUM_LD x FTQ_W | Fetch-queue pointer per port |
| ld_off | input | NUM_LD x OFF_W | Instruction offset |
| ld_target | input | NUM_LD x PC_W | Carried redirect target |
| flush_valid | input | 1 | Commit-time flush valid |
| flush_rob | input | ROB_W | Flush reorder-buffer index value |
| flush_wrap | input | 1 | Flush wrap flag |
| flush_self | input | 1 | Flush-self flag of the flush |
| flush_ftq | input | FTQ_W | Flush fetch-queue pointer |
| flush_off | input | OFF_W | Flush instruction offset |
| base_pc | input | PC_W | Base PC read back for `pc_rd_ftq` |
| pc_rd_ftq | output | FTQ_W | Read pointer into the fetch-address memory |
| ahead_ftq | output | 3 x FTQ_W | Look-ahead queue pointers per source slot |
| out_valid | output | 1 | Redirect issued this cycle |
| out_sel_oh | output | 3 | One-hot source of the issued redirect |
| out_rob | output | ROB_W | Issued reorder-buffer index value |
| out_wrap | output | 1 | Issued wrap flag |
| out_self | output | 1 | Issued flush-self flag |
| out_ftq | output | FTQ_W | Issued fetch-queue pointer |
| out_pc | output | PC_W | PC of the redirecting instruction |
| out_target | output | PC_W | Fetch restart address |

## Verification
The hardest situation to reach is a request that is already in flight when an older redirect is issued, especially one of exactly equal age. It must arrive so that it sits in a given stage during the single cycle in which the cancelling redirect is on the output. Directed sequences place a younger request and an equal-age request at the input in precisely that cycle, with the flush-self flag both set and clear. A flush is timed to meet a branch candidate in the same stage. Random traffic then keeps drawing indices from a narrow window just ahead of a slowly advancing age counter that wraps. Close ages, equal ages, wrap crossings and overlapping cancels therefore occur many times.

// File: rtl/rdr_arb_pkg.sv
package rdr_arb_pkg;

    parameter int ROB_W      = 8;
    parameter int FTQ_W      = 6;
    parameter int OFF_W      = 4;
    parameter int PC_W       = 32;
    parameter int INST_BYTES = 4;

    localparam int NSRC    = 3;
    localparam int SRC_EXU = 0;
    localparam int SRC_LD  = 1;
    localparam int SRC_FL  = 2;

    typedef struct packed {
        logic             wrap;
        logic [ROB_W-1:0] val;
    } rob_idx_t;

    typedef struct packed {
        rob_idx_t         idx;
        logic             self_flush;
        logic [FTQ_W-1:0] ftq;
        logic [OFF_W-1:0] off;
        logic [PC_W-1:0]  target;
    } rdr_req_t;

    // a precedes b in program order
    function automatic logic idx_older(rob_idx_t a, rob_idx_t b);
        return (a.wrap == b.wrap) ? (a.val < b.val) : (a.val > b.val);
    endfunction

    // request r is cancelled by an issued redirect c
    function automatic logic is_cancelled(rob_idx_t r, rob_idx_t c, logic c_self);
        return idx_older(c, r) || ((r == c) && c_self);
    endfunction

endpackage

// File: rtl/rdr_cancel_mask.sv
module rdr_cancel_mask
    import rdr_arb_pkg::*;
#(
    parameter int N = 1
) (
    input  rdr_req_t [N-1:0] reqs,
    input  logic     [N-1:0] req_v,
    input  logic             cancel_v,
    input  rob_idx_t         cancel_idx,
    input  logic             cancel_self,
    output logic     [N-1:0] keep_v
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_mask
            assign keep_v[i] = req_v[i] &&
                !(cancel_v && is_cancelled(reqs[i].idx, cancel_idx, cancel_self));
        end
    endgenerate

endmodule

// File: rtl/rdr_oldest_pick.sv
module rdr_oldest_pick
    import rdr_arb_pkg::*;
#(
    parameter int N = 2
) (
    input  rdr_req_t [N-1:0] reqs,
    input  logic     [N-1:0] req_v,
    output logic             win_v,
    output rdr_req_t         win
);

    // strict comparison keeps the lowest port on equal age
    always_comb begin
        win_v = 1'b0;
        win   = '0;
        for (int i = 0; i < N; i++) begin
            if (req_v[i] && (!win_v || idx_older(reqs[i].idx, win.idx))) begin
                win_v = 1'b1;
                win   = reqs[i];
            end
        end
    end

endmodule

// File: rtl/rdr_target_calc.sv
module rdr_target_calc
    import rdr_arb_pkg::*;
(
    input  logic [PC_W-1:0]  base,
    input  logic [OFF_W-1:0] off,
    input  logic             self_flush,
    input  logic             from_flush,
    input  logic [PC_W-1:0]  carried,
    output logic [PC_W-1:0]  pc,
    output logic [PC_W-1:0]  target
);

    localparam int SHIFT = $clog2(INST_BYTES);
    localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

    always_comb begin
        pc = base + (PC_W'(off) << SHIFT);
        if (self_flush)      target = pc;
        else if (from_flush) target = pc + STEP;
        else                 target = carried;
    end

endmodule

// File: rtl/redirect_arbiter.sv
module redirect_arbiter
    import rdr_arb_pkg::*;
#(
    parameter int NUM_EXU = 3,
    parameter int NUM_LD  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_EXU-1:0]              exu_valid,
    input  logic [NUM_EXU-1:0][ROB_W-1:0]   exu_rob,
    input  logic [NUM_EXU-1:0]              exu_wrap,
    input  logic [NUM_EXU-1:0]              exu_self,
    input  logic [NUM_EXU-1:0][FTQ_W-1:0]   exu_ftq,
    input  logic [NUM_EXU-1:0][OFF_W-1:0]   exu_off,
    input  logic [NUM_EXU-1:0][PC_W-1:0]    exu_target,
    input  logic [NUM_LD-1:0]               ld_valid,
    input  logic [NUM_LD-1:0][ROB_W-1:0]    ld_rob,
    input  logic [NUM_LD-1:0]               ld_wrap,
    input  logic [NUM_LD-1:0]               ld_self,
    input  logic [NUM_LD-1:0][FTQ_W-1:0]    ld_ftq,
    input  logic [NUM_LD-1:0][OFF_W-1:0]    ld_off,
    input  logic [NUM_LD-1:0][PC_W-1:0]     ld_target,
    input  logic                            flush_valid,
    input  logic [ROB_W-1:0]                flush_rob,
    input  logic                            flush_wrap,
    input  logic                            flush_self,
    input  logic [FTQ_W-1:0]                flush_ftq,
    input  logic [OFF_W-1:0]                flush_off,
    input  logic [PC_W-1:0]                 base_pc,
    output logic [FTQ_W-1:0]                pc_rd_ftq,
    output logic [NSRC-1:0][FTQ_W-1:0]      ahead_ftq,
    output logic                            out_valid,
    output logic [NSRC-1:0]                 out_sel_oh,
    output logic [ROB_W-1:0]                out_rob,
    output logic                            out_wrap,
    output logic                            out_self,
    output logic [FTQ_W-1:0]                out_ftq,
    output logic [PC_W-1:0]                 out_pc,
    output logic [PC_W-1:0]                 out_target
);

    typedef struct packed {
        logic [NUM_EXU-1:0]            s0_exu_v;
        rdr_req_t [NUM_EXU-1:0]        s0_exu;
        logic [NUM_LD-1:0]             s0_ld_v;
        rdr_req_t [NUM_LD-1:0]         s0_ld;
        logic                          s1_v;
        logic                          s1_from_ld;
        rdr_req_t                      s1_win;
        logic [FTQ_W-1:0]              s1_ahead_exu;
        logic [FTQ_W-1:0]              s1_ahead_ld;
        logic                          fl_v;
        rdr_req_t                      fl;
        logic                          out_v;
        logic [NSRC-1:0]               out_oh;
        rdr_req_t                      out;
        logic [PC_W-1:0]               out_pc;
    } state_t;

    state_t st_d, st_q;

    rdr_req_t [NUM_EXU-1:0] exu_in;
    rdr_req_t [NUM_LD-1:0]  ld_in;
    rdr_req_t               fl_in;
    rdr_req_t [0:0]         s1_arr;
    rdr_req_t               stage_rec;

    logic [NUM_EXU-1:0] keep_in_exu, keep_s0_exu;
    logic [NUM_LD-1:0]  keep_in_ld, keep_s0_ld;
    logic [0:0]         keep_s1;
    logic               exu_win_v, ld_win_v, ld_takes;
    rdr_req_t           exu_win, ld_win;
    logic [PC_W-1:0]    calc_pc, calc_target;

    // pack the port vectors into request records
    always_comb begin
        for (int i = 0; i < NUM_EXU; i++) begin
            exu_in[i].idx.wrap   = exu_wrap[i];
            exu_in[i].idx.val    = exu_rob[i];
            exu_in[i].self_flush = exu_self[i];
            exu_in[i].ftq        = exu_ftq[i];
            exu_in[i].off        = exu_off[i];
            exu_in[i].target     = exu_target[i];
        end
        for (int i = 0; i < NUM_LD; i++) begin
            ld_in[i].idx.wrap    = ld_wrap[i];
            ld_in[i].idx.val     = ld_rob[i];
            ld_in[i].self_flush  = ld_self[i];
            ld_in[i].ftq         = ld_ftq[i];
            ld_in[i].off         = ld_off[i];
            ld_in[i].target      = ld_target[i];
        end
        fl_in.idx.wrap   = flush_wrap;
        fl_in.idx.val    = flush_rob;
        fl_in.self_flush = flush_self;
        fl_in.ftq        = flush_ftq;
        fl_in.off        = flush_off;
        fl_in.target     = '0;
    end

    assign s1_arr[0] = st_q.s1_win;

    // every stage is filtered by the redirect currently on the output
    rdr_cancel_mask #(.N(NUM_EXU)) u_cm_in_exu (
        .reqs(exu_in), .req_v(exu_valid), .cancel_v(st_q.out_v),
        .cancel_idx(st_q.out.idx), .cancel_self(st_q.out.self_flush), .keep_v(keep_in_exu));
    rdr_cancel_mask #(.N(NUM_LD)) u_cm_in_ld (
        .reqs(ld_in), .req_v(ld_valid), .cancel_v(st_q.out_v),
        .cancel_idx(st_q.out.idx), .cancel_self(st_q.out.self_flush), .keep_v(keep_in_ld));
    rdr_cancel_mask #(.N(NUM_EXU)) u_cm_s0_exu (
        .reqs(st_q.s0_exu), .req_v(st_q.s0_exu_v), .cancel_v(st_q.out_v),
        .cancel_idx(st_q.out.idx), .cancel_self(st_q.out.self_flush), .keep_v(keep_s0_exu));
    rdr_cancel_mask #(.N(NUM_LD)) u_cm_s0_ld (
        .reqs(st_q.s0_ld), .req_v(st_q.s0_ld_v), .cancel_v(st_q.out_v),
        .cancel_idx(st_q.out.idx), .cancel_self(st_q.out.self_flush), .keep_v(keep_s0_ld));
    rdr_cancel_mask #(.N(1)) u_cm_s1 (
        .reqs(s1_arr), .req_v(st_q.s1_v), .cancel_v(st_q.out_v),
        .cancel_idx(st_q.out.idx), .cancel_self(st_q.out.self_flush), .keep_v(keep_s1));

    rdr_oldest_pick #(.N(NUM_EXU)) u_pick_exu (
        .reqs(st_q.s0_exu), .req_v(keep_s0_exu), .win_v(exu_win_v), .win(exu_win));
    rdr_oldest_pick #(.N(NUM_LD)) u_pick_ld (
        .reqs(st_q.s0_ld), .req_v(keep_s0_ld), .win_v(ld_win_v), .win(ld_win));

    assign stage_rec = st_q.fl_v ? st_q.fl : st_q.s1_win;

    rdr_target_calc u_tgt (
        .base(base_pc), .off(stage_rec.off), .self_flush(stage_rec.self_flush),
        .from_flush(st_q.fl_v), .carried(stage_rec.target),
        .pc(calc_pc), .target(calc_target));

    always_comb begin
        st_d = st_q;

        // stage 0: register surviving write-back requests
        st_d.s0_exu_v = keep_in_exu;
        st_d.s0_exu   = exu_in;
        st_d.s0_ld_v  = keep_in_ld;
        st_d.s0_ld    = ld_in;

        // stage 1: branch winner against load winner, load only if strictly older
        ld_takes          = ld_win_v && (!exu_win_v || idx_older(ld_win.idx, exu_win.idx));
        st_d.s1_v         = exu_win_v || ld_win_v;
        st_d.s1_from_ld   = ld_takes;
        st_d.s1_win       = ld_takes ? ld_win : exu_win;
        st_d.s1_ahead_exu = exu_win.ftq;
        st_d.s1_ahead_ld  = ld_win.ftq;

        // commit flush takes a single delay stage
        st_d.fl_v = flush_valid;
        st_d.fl   = fl_in;

        // output: flush first, then a surviving execution candidate
        st_d.out_v      = st_q.fl_v || keep_s1[0];
        st_d.out        = stage_rec;
        st_d.out.target = calc_target;
        st_d.out_pc     = calc_pc;
        if (st_q.fl_v)
            st_d.out_oh = NSRC'(1) << SRC_FL;
        else if (keep_s1[0])
            st_d.out_oh = st_q.s1_from_ld ? (NSRC'(1) << SRC_LD) : (NSRC'(1) << SRC_EXU);
        else
            st_d.out_oh = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_rd_ftq         = stage_rec.ftq;
    assign ahead_ftq[SRC_EXU] = st_q.s1_ahead_exu;
    assign ahead_ftq[SRC_LD]  = st_q.s1_ahead_ld;
    assign ahead_ftq[SRC_FL]  = st_q.fl.ftq;
    assign out_valid  = st_q.out_v;
    assign out_sel_oh = st_q.out_oh;
    assign out_rob    = st_q.out.idx.val;
    assign out_wrap   = st_q.out.idx.wrap;
    assign out_self   = st_q.out.self_flush;
    assign out_ftq    = st_q.out.ftq;
    assign out_pc     = st_q.out_pc;
    assign out_target = st_q.out.target;

endmodule

// File: rtl/rdr_arb_checker.sv
module rdr_arb_checker
    import rdr_arb_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       flush_valid,
    input logic [FTQ_W-1:0]           pc_rd_ftq,
    input logic [NSRC-1:0][FTQ_W-1:0] ahead_ftq,
    input logic                       out_valid,
    input logic [NSRC-1:0]            out_sel_oh,
    input logic [ROB_W-1:0]           out_rob,
    input logic                       out_wrap,
    input logic                       out_self,
    input logic [FTQ_W-1:0]           out_ftq,
    input logic [PC_W-1:0]            out_pc,
    input logic [PC_W-1:0]            out_target
);

    function automatic logic ahead_of(logic aw, logic [ROB_W-1:0] av,
                                      logic bw, logic [ROB_W-1:0] bv);
        return (aw == bw) ? (av < bv) : (av > bv);
    endfunction

    a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_sel_oh) == 1);

    a_r8_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_sel_oh == '0);

    a_r7_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> ##2 (out_valid && out_sel_oh[SRC_FL]));

    a_r9_ahead_exu: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sel_oh[SRC_EXU]) |-> out_ftq == $past(ahead_ftq[SRC_EXU]));

    a_r9_ahead_ld: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sel_oh[SRC_LD]) |-> out_ftq == $past(ahead_ftq[SRC_LD]));

    a_r9_ahead_fl: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sel_oh[SRC_FL]) |-> out_ftq == $past(ahead_ftq[SRC_FL]));

    a_r11_read_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_ftq == $past(pc_rd_ftq));

    a_r10_self_target: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_self) |-> out_target == out_pc);

    a_r6_no_younger_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid) && !out_sel_oh[SRC_FL]) |->
            (ahead_of(out_wrap, out_rob, $past(out_wrap), $past(out_rob)) ||
             ({out_wrap, out_rob} == {$past(out_wrap), $past(out_rob)} && !$past(out_self))));

endmodule

bind redirect_arbiter rdr_arb_checker u_chk (.*);

// File: tb/redirect_arbiter_tb.sv
module redirect_arbiter_tb;
    import rdr_arb_pkg::ROB_W;
    import rdr_arb_pkg::FTQ_W;
    import rdr_arb_pkg::OFF_W;
    import rdr_arb_pkg::PC_W;

    localparam int NE = 3;
    localparam int NL = 3;

    typedef struct {
        bit             v;
        bit             wrap;
        bit [ROB_W-1:0] val;
        bit             self;
        bit [FTQ_W-1:0] ftq;
        bit [OFF_W-1:0] off;
        bit [PC_W-1:0]  tgt;
    } mreq_t;

    logic clk = 0;
    logic rst_n = 0;
    always #5 clk = ~clk;

    logic [NE-1:0] exu_valid, exu_wrap, exu_self;
    logic [NE-1:0][ROB_W-1:0] exu_rob;
    logic [NE-1:0][FTQ_W-1:0] exu_ftq;
    logic [NE-1:0][OFF_W-1:0] exu_off;
    logic [NE-1:0][PC_W-1:0]  exu_target;
    logic [NL-1:0] ld_valid, ld_wrap, ld_self;
    logic [NL-1:0][ROB_W-1:0] ld_rob;
    logic [NL-1:0][FTQ_W-1:0] ld_ftq;
    logic [NL-1:0][OFF_W-1:0] ld_off;
    logic [NL-1:0][PC_W-1:0]  ld_target;
    logic flush_valid, flush_wrap, flush_self;
    logic [ROB_W-1:0] flush_rob;
    logic [FTQ_W-1:0] flush_ftq;
    logic [OFF_W-1:0] flush_off;
    logic [PC_W-1:0]  base_pc;
    logic [FTQ_W-1:0] pc_rd_ftq;
    logic [2:0][FTQ_W-1:0] ahead_ftq;
    logic out_valid, out_wrap, out_self;
    logic [2:0] out_sel_oh;
    logic [ROB_W-1:0] out_rob;
    logic [FTQ_W-1:0] out_ftq;
    logic [PC_W-1:0] out_pc, out_target;

    mreq_t in_e[NE], in_l[NL], in_f;
    mreq_t m_s0e[NE], m_s0l[NL], m_s1, m_fl, m_out;
    bit m_s1_ld;
    bit [FTQ_W-1:0] m_ah_e, m_ah_l;
    bit [2:0] m_oh;
    bit [PC_W-1:0] m_pc, m_tgt;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    function automatic bit [PC_W-1:0] mem_base(bit [FTQ_W-1:0] p);
        return 32'h8000_0000 + (PC_W'(p) << 6);
    endfunction

    assign base_pc = mem_base(pc_rd_ftq);

    always_comb begin
        for (int i = 0; i < NE; i++) begin
            exu_valid[i] = in_e[i].v; exu_wrap[i] = in_e[i].wrap; exu_rob[i] = in_e[i].val;
            exu_self[i] = in_e[i].self; exu_ftq[i] = in_e[i].ftq; exu_off[i] = in_e[i].off;
            exu_target[i] = in_e[i].tgt;
        end
        for (int i = 0; i < NL; i++) begin
            ld_valid[i] = in_l[i].v; ld_wrap[i] = in_l[i].wrap; ld_rob[i] = in_l[i].val;
            ld_self[i] = in_l[i].self; ld_ftq[i] = in_l[i].ftq; ld_off[i] = in_l[i].off;
            ld_target[i] = in_l[i].tgt;
        end
        flush_valid = in_f.v; flush_wrap = in_f.wrap; flush_rob = in_f.val;
        flush_self = in_f.self; flush_ftq = in_f.ftq; flush_off = in_f.off;
    end

    redirect_arbiter #(.NUM_EXU(NE), .NUM_LD(NL)) u_dut (.*);

    // R5 age order
    function automatic bit older(mreq_t a, mreq_t b);
        return (a.wrap == b.wrap) ? (a.val < b.val) : (a.val > b.val);
    endfunction

    // R6 cancel rule
    function automatic bit dropped(mreq_t r, mreq_t c);
        return c.v && (older(c, r) || (r.wrap == c.wrap && r.val == c.val && c.self));
    endfunction

    function automatic mreq_t mk(bit w, int v, bit s, int f, int o, bit [PC_W-1:0] t);
        mreq_t r;
        r.v = 1; r.wrap = w; r.val = ROB_W'(v); r.self = s;
        r.ftq = FTQ_W'(f); r.off = OFF_W'(o); r.tgt = t;
        return r;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        for (int i = 0; i < NE; i++) in_e[i] = '{default: 0};
        for (int i = 0; i < NL; i++) in_l[i] = '{default: 0};
        in_f = '{default: 0};
    endtask

    task automatic compare();
        chk("R8 out_valid", 64'(out_valid), 64'(m_out.v));
        chk("R8 out_sel_oh", 64'(out_sel_oh), 64'(m_oh));
        chk("R9 ahead exu", 64'(ahead_ftq[0]), 64'(m_ah_e));
        chk("R9 ahead ld", 64'(ahead_ftq[1]), 64'(m_ah_l));
        chk("R9 ahead flush", 64'(ahead_ftq[2]), 64'(m_fl.ftq));
        chk("R11 pc_rd_ftq", 64'(pc_rd_ftq), 64'(m_fl.v ? m_fl.ftq : m_s1.ftq));
        if (m_out.v) begin
            chk("R3 out index", 64'({out_wrap, out_rob}), 64'({m_out.wrap, m_out.val}));
            chk("R3 out self", 64'(out_self), 64'(m_out.self));
            chk("R3 out ftq", 64'(out_ftq), 64'(m_out.ftq));
            chk("R10 out_pc", 64'(out_pc), 64'(m_pc));
            chk("R10 out_target", 64'(out_target), 64'(m_tgt));
        end
    endtask

    // one clock: model next state from current inputs, then compare
    task automatic step();
        mreq_t ne[NE], nl[NL], be, bl, ns1, src, nout;
        bit nld;
        bit [2:0] noh;
        bit [PC_W-1:0] npc, ntgt;
        for (int i = 0; i < NE; i++) begin
            ne[i] = in_e[i]; ne[i].v = in_e[i].v && !dropped(in_e[i], m_out);
        end
        for (int i = 0; i < NL; i++) begin
            nl[i] = in_l[i]; nl[i].v = in_l[i].v && !dropped(in_l[i], m_out);
        end
        be = '{default: 0}; bl = '{default: 0};
        for (int i = 0; i < NE; i++)
            if (m_s0e[i].v && !dropped(m_s0e[i], m_out) && (!be.v || older(m_s0e[i], be))) be = m_s0e[i];
        for (int i = 0; i < NL; i++)
            if (m_s0l[i].v && !dropped(m_s0l[i], m_out) && (!bl.v || older(m_s0l[i], bl))) bl = m_s0l[i];
        nld = bl.v && (!be.v || older(bl, be));
        ns1 = nld ? bl : be;
        ns1.v = be.v || bl.v;
        src = m_fl.v ? m_fl : m_s1;
        npc = mem_base(src.ftq) + (PC_W'(src.off) << 2);
        ntgt = src.self ? npc : (m_fl.v ? npc + 4 : src.tgt);
        nout = src;
        nout.v = m_fl.v || (m_s1.v && !dropped(m_s1, m_out));
        noh = m_fl.v ? 3'b100 : (nout.v ? (m_s1_ld ? 3'b010 : 3'b001) : 3'b000);
        @(posedge clk);
        m_s0e = ne; m_s0l = nl;
        m_s1 = ns1; m_s1_ld = nld; m_ah_e = be.ftq; m_ah_l = bl.ftq;
        m_fl = in_f; m_out = nout; m_oh = noh; m_pc = npc; m_tgt = ntgt;
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        bit [8:0] age;
        seed = 32'd20240611;
        void'($urandom(seed));
        clear_in();
        for (int i = 0; i < NE; i++) m_s0e[i] = '{default: 0};
        for (int i = 0; i < NL; i++) m_s0l[i] = '{default: 0};
        m_s1 = '{default: 0}; m_fl = '{default: 0}; m_out = '{default: 0};
        m_s1_ld = 0; m_ah_e = 0; m_ah_l = 0; m_oh = 0; m_pc = 0; m_tgt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 reset out_valid", 64'(out_valid), 64'd0);
        chk("R1 reset out_sel_oh", 64'(out_sel_oh), 64'd0);

        // R2 R3: two branch ports, port 2 older, three-edge latency
        in_e[1] = mk(0, 20, 0, 3, 1, 32'h1000);
        in_e[2] = mk(0, 12, 0, 7, 2, 32'h2000);
        step(); clear_in();
        chk("R2 not yet after edge 1", 64'(out_valid), 64'd0);
        step();
        chk("R2 not yet after edge 2", 64'(out_valid), 64'd0);
        step();
        chk("R2 R3 oldest branch issued", 64'({out_valid, out_rob}), 64'({1'b1, 8'd12}));
        chk("R10 branch carried target", 64'(out_target), 64'h2000);
        repeat (2) step();

        // R5: differing wrap flags, larger value is older
        in_e[0] = mk(0, 250, 0, 1, 0, 32'h3000);
        in_e[1] = mk(1, 3, 0, 2, 0, 32'h3100);
        step(); clear_in(); step(); step();
        chk("R5 wrap compare", 64'({out_wrap, out_rob}), 64'({1'b0, 8'd250}));
        repeat (2) step();

        // R4: equal age goes to branch, strictly older load wins
        in_e[0] = mk(0, 40, 0, 4, 0, 32'h4000);
        in_l[0] = mk(0, 40, 1, 5, 0, 32'h4100);
        step(); clear_in(); step(); step();
        chk("R4 tie to branch", 64'(out_sel_oh), 64'b001);
        repeat (2) step();
        in_e[0] = mk(0, 40, 0, 4, 0, 32'h4000);
        in_l[2] = mk(0, 39, 1, 6, 0, 32'h4200);
        step(); clear_in(); step(); step();
        chk("R4 older load wins", 64'({out_sel_oh, out_rob}), 64'({3'b010, 8'd39}));
        repeat (2) step();

        // R7: flush meets branch candidate in the same cycle; branch is discarded
        in_e[0] = mk(0, 90, 0, 8, 1, 32'h5000);
        step(); clear_in();
        in_f = mk(0, 85, 0, 5, 3, 0);
        step(); clear_in(); step();
        chk("R7 flush wins", 64'({out_sel_oh, out_rob}), 64'({3'b100, 8'd85}));
        chk("R10 flush target next", 64'(out_target), 64'(mem_base(5) + 12 + 4));
        step();
        chk("R7 branch discarded", 64'(out_valid), 64'd0);
        repeat (2) step();

        // R6: self-flushing redirect drops younger and equal-age arrivals
        in_e[0] = mk(0, 30, 1, 9, 0, 32'h6000);
        step(); clear_in(); step(); step();
        chk("R6 first issued", 64'(out_valid), 64'd1);
        in_e[1] = mk(0, 30, 0, 10, 0, 32'h6100);
        in_l[0] = mk(0, 31, 0, 11, 0, 32'h6200);
        step(); clear_in();
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R6 equal and younger dropped", 64'(out_valid), 64'd0);
        end
        // R6: non-self redirect keeps an equal-age arrival
        in_e[0] = mk(0, 50, 0, 12, 0, 32'h7000);
        step(); clear_in(); step(); step();
        in_e[2] = mk(0, 50, 0, 13, 0, 32'h7100);
        step(); clear_in(); step(); step();
        chk("R6 equal kept without self", 64'({out_valid, out_ftq}), 64'({1'b1, 6'd13}));
        repeat (2) step();

        // random traffic around a moving, wrapping age window
        age = 9'd100;
        for (int c = 0; c < 3000; c++) begin
            clear_in();
            for (int i = 0; i < NE; i++)
                if ($urandom_range(3) == 0) begin
                    bit [8:0] a = age + 9'($urandom_range(24));
                    in_e[i] = mk(a[8], int'(a[7:0]), 1'($urandom_range(1)),
                                 int'($urandom_range(63)), int'($urandom_range(15)), $urandom);
                end
            for (int i = 0; i < NL; i++)
                if ($urandom_range(4) == 0) begin
                    bit [8:0] a = age + 9'($urandom_range(24));
                    in_l[i] = mk(a[8], int'(a[7:0]), 1'($urandom_range(1)),
                                 int'($urandom_range(63)), int'($urandom_range(15)), $urandom);
                end
            if ($urandom_range(39) == 0)
                in_f = mk(age[8], int'(age[7:0]), 1'($urandom_range(1)),
                          int'($urandom_range(63)), int'($urandom_range(15)), 0);
            step();
            age = age + 9'($urandom_range(3));
        end
        clear_in();
        repeat (4) step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule